// File: doc/BRIEF.md
# Media Timestamp Counter Unit

This block keeps the time base that an audio subsystem uses to pair samples with wall-clock time. A 64-bit counter advances once per microsecond tick from reset. Each audio channel keeps a running count of the samples it has processed. Alongside that count it keeps a snapshot of the low 32 bits of the time counter, taken on the same strobe that advances the count.

Software reaches every value through a simple registered read port. Each channel's count and snapshot form a pair that must read back as one coherent unit. Reading the count therefore freezes the snapshot word that software sees next. Reading the snapshot word releases it. Sample strobes arriving between the two reads keep advancing the live pair, but do not disturb the frozen word. A parameter sets the time counter's value after reset, so that a design can start at a chosen point and the word carry can be exercised in a short run.

Top module: `media_stamp_unit`

## Requirements
- R1: Reset loads the time counter with TIME_START (zero by default) and clears every sample count, snapshot, freeze flag and the read data output to zero.
- R2: The time counter increases by exactly one in each cycle where `us_tick` is high, and holds otherwise. Its low word reads at address 0x200.
- R3: The high word of the time counter reads at address 0x204. It increments when the low word wraps from 0xFFFFFFFF to 0.
- R4: Channel c's sample count (c = 0 at 0x304, c = 1 at 0x30C, stride 8) increments by one in each cycle where `sample_stb[c]` is high. The channels are independent of one another.
- R5: On a sample strobe, the channel's live snapshot loads the low word of the time counter as it stood in that cycle, before any tick in the same cycle takes effect. Channel c's snapshot word is at 0x300 + 8*c.
- R6: A read of a channel's count address freezes that channel's snapshot word. Until the snapshot address is read, that word returns the snapshot that belonged to the count just read, even if further strobes arrive.
- R7: A read of the snapshot address releases the freeze. Later snapshot reads return the live snapshot, until the count is read again.
- R8: Read data appears on `rd_data` one cycle after the cycle in which `rd_en` is high. It holds while `rd_en` is low. An unmapped address returns zero.
- R9: If a count read and a strobe on the same channel happen in the same cycle, the read returns the count from before the strobe. The following snapshot read returns the snapshot paired with that older count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| sample_stb | input | NUM_CH | Per-channel processed-sample strobe |
| rd_en | input | 1 | Read request, one cycle |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | WORD_W | Registered read data |

## Verification
Every register read lands on `rd_data` one clock after the rising edge that samples `rd_en`. The bench drives inputs at the falling edge and takes read data at the next falling edge, which is exactly one rising edge later. A tick or strobe driven for one cycle changes the state at that cycle's rising edge, so a read issued in any later cycle already sees it. The bench keeps its own model of the time counter from the ticks it drives. It predicts snapshots from that model, using the value before the tick whenever a strobe and a tick share a cycle.

// File: rtl/mstamp_pkg.sv
package mstamp_pkg;

    localparam int WORD_W = 32;
    localparam int TIME_W = 2 * WORD_W;

    // register word addresses
    localparam int TIME_LO_ADDR = 'h200;
    localparam int TIME_HI_ADDR = 'h204;
    localparam int CH_BASE      = 'h300;
    localparam int CH_STRIDE    = 8;
    localparam int SNAP_OFS     = 0;
    localparam int CNT_OFS      = 4;

    typedef struct packed {
        logic [TIME_W-1:0] count;
    } time_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] cnt;
        logic [WORD_W-1:0] snap;
        logic [WORD_W-1:0] held;
        logic              frozen;
    } chan_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
    } read_state_t;

endpackage

// File: rtl/mstamp_time_base.sv
module mstamp_time_base
    import mstamp_pkg::*;
#(
    parameter logic [TIME_W-1:0] START = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    output logic [TIME_W-1:0] time_o
);

    time_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (tick_i) begin
            state_d.count = state_q.count + TIME_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{count: START};
        end else begin
            state_q <= state_d;
        end
    end

    assign time_o = state_q.count;

endmodule

// File: rtl/mstamp_channel.sv
module mstamp_channel
    import mstamp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [WORD_W-1:0] time_lo_i,
    input  logic              cnt_rd_i,
    input  logic              snap_rd_i,
    output logic [WORD_W-1:0] cnt_o,
    output logic [WORD_W-1:0] snap_view_o,
    output logic [WORD_W-1:0] held_o,
    output logic              frozen_o
);

    chan_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // live pair always advances together
        if (strobe_i) begin
            state_d.cnt  = state_q.cnt + WORD_W'(1);
            state_d.snap = time_lo_i;
        end
        // count read captures the partner of the count being returned
        if (cnt_rd_i) begin
            state_d.held   = state_q.snap;
            state_d.frozen = 1'b1;
        end else if (snap_rd_i) begin
            state_d.frozen = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o       = state_q.cnt;
    assign snap_view_o = state_q.frozen ? state_q.held : state_q.snap;
    assign held_o      = state_q.held;
    assign frozen_o    = state_q.frozen;

endmodule

// File: rtl/mstamp_read_port.sv
module mstamp_read_port
    import mstamp_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           rd_en_i,
    input  logic [ADDR_W-1:0]              rd_addr_i,
    input  logic [TIME_W-1:0]              time_i,
    input  logic [NUM_CH-1:0][WORD_W-1:0]  cnt_i,
    input  logic [NUM_CH-1:0][WORD_W-1:0]  snap_i,
    output logic [NUM_CH-1:0]              cnt_rd_o,
    output logic [NUM_CH-1:0]              snap_rd_o,
    output logic [WORD_W-1:0]              rd_data_o
);

    read_state_t state_d, state_q;

    always_comb begin
        cnt_rd_o  = '0;
        snap_rd_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            cnt_rd_o[c]  = rd_en_i &&
                (rd_addr_i == ADDR_W'(CH_BASE + c * CH_STRIDE + CNT_OFS));
            snap_rd_o[c] = rd_en_i &&
                (rd_addr_i == ADDR_W'(CH_BASE + c * CH_STRIDE + SNAP_OFS));
        end
    end

    always_comb begin
        state_d = state_q;
        if (rd_en_i) begin
            state_d.data = '0;
            if (rd_addr_i == ADDR_W'(TIME_LO_ADDR)) begin
                state_d.data = time_i[WORD_W-1:0];
            end
            if (rd_addr_i == ADDR_W'(TIME_HI_ADDR)) begin
                state_d.data = time_i[TIME_W-1:WORD_W];
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (cnt_rd_o[c]) begin
                    state_d.data = cnt_i[c];
                end
                if (snap_rd_o[c]) begin
                    state_d.data = snap_i[c];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data_o = state_q.data;

endmodule

// File: rtl/media_stamp_unit.sv
module media_stamp_unit
    import mstamp_pkg::*;
#(
    parameter int                NUM_CH     = 2,
    parameter int                ADDR_W     = 12,
    parameter logic [TIME_W-1:0] TIME_START = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic [NUM_CH-1:0] sample_stb,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [TIME_W-1:0]             time_q;
    logic [NUM_CH-1:0][WORD_W-1:0] cnt_all;
    logic [NUM_CH-1:0][WORD_W-1:0] snap_all;
    logic [NUM_CH-1:0][WORD_W-1:0] held_all;
    logic [NUM_CH-1:0]             frozen_all;
    logic [NUM_CH-1:0]             cnt_rd;
    logic [NUM_CH-1:0]             snap_rd;

    mstamp_time_base #(
        .START (TIME_START)
    ) u_time (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (us_tick),
        .time_o (time_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        mstamp_channel u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .strobe_i    (sample_stb[g]),
            .time_lo_i   (time_q[WORD_W-1:0]),
            .cnt_rd_i    (cnt_rd[g]),
            .snap_rd_i   (snap_rd[g]),
            .cnt_o       (cnt_all[g]),
            .snap_view_o (snap_all[g]),
            .held_o      (held_all[g]),
            .frozen_o    (frozen_all[g])
        );
    end

    mstamp_read_port #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .time_i    (time_q),
        .cnt_i     (cnt_all),
        .snap_i    (snap_all),
        .cnt_rd_o  (cnt_rd),
        .snap_rd_o (snap_rd),
        .rd_data_o (rd_data)
    );

endmodule

// File: rtl/mstamp_checker.sv
module mstamp_checker
    import mstamp_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 12
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          us_tick,
    input logic [NUM_CH-1:0]             sample_stb,
    input logic                          rd_en,
    input logic [ADDR_W-1:0]             rd_addr,
    input logic [WORD_W-1:0]             rd_data,
    input logic [TIME_W-1:0]             time_q,
    input logic [NUM_CH-1:0][WORD_W-1:0] cnt_all,
    input logic [NUM_CH-1:0][WORD_W-1:0] held_all,
    input logic [NUM_CH-1:0]             frozen_all
);

    logic [NUM_CH-1:0] cnt_hit, snap_hit;
    logic              mapped;

    always_comb begin
        cnt_hit  = '0;
        snap_hit = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            cnt_hit[c]  = rd_en && (rd_addr == ADDR_W'(CH_BASE + c * CH_STRIDE + CNT_OFS));
            snap_hit[c] = rd_en && (rd_addr == ADDR_W'(CH_BASE + c * CH_STRIDE + SNAP_OFS));
        end
        mapped = (|cnt_hit) || (|snap_hit) ||
                 (rd_addr == ADDR_W'(TIME_LO_ADDR)) || (rd_addr == ADDR_W'(TIME_HI_ADDR));
    end

    p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        us_tick |=> time_q == $past(time_q) + 64'd1);

    p_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !us_tick |=> $stable(time_q));

    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> rd_data == '0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
            sample_stb[g] |=> cnt_all[g] == $past(cnt_all[g]) + 32'd1);

        p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !sample_stb[g] |=> $stable(cnt_all[g]));

        p_freeze_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_hit[g] |=> frozen_all[g]);

        p_held_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (frozen_all[g] && !cnt_hit[g]) |=> $stable(held_all[g]));

        p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
            snap_hit[g] |=> !frozen_all[g]);
    end

endmodule

bind media_stamp_unit mstamp_checker #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .us_tick    (us_tick),
    .sample_stb (sample_stb),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .time_q     (time_q),
    .cnt_all    (cnt_all),
    .held_all   (held_all),
    .frozen_all (frozen_all)
);

// File: tb/media_stamp_unit_test.sv
`timescale 1ns/1ps
module media_stamp_unit_test;

    localparam logic [63:0] START = 64'h0000_0000_FFFF_FFF8;
    localparam logic [11:0] A_LO   = 12'h200;
    localparam logic [11:0] A_HI   = 12'h204;
    localparam logic [11:0] A_S0   = 12'h300;
    localparam logic [11:0] A_C0   = 12'h304;
    localparam logic [11:0] A_S1   = 12'h308;
    localparam logic [11:0] A_C1   = 12'h30C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic [1:0]  sample_stb = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [63:0] exp_time = START;

    always #2 clk = ~clk;

    media_stamp_unit #(
        .NUM_CH     (2),
        .ADDR_W     (12),
        .TIME_START (START)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .us_tick    (us_tick),
        .sample_stb (sample_stb),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            us_tick = 1'b1;
            exp_time = exp_time + 64'd1;
        end
        @(negedge clk);
        us_tick = 1'b0;
    endtask

    // one-cycle strobe on channel ch, optionally with a tick in the same cycle
    task automatic strobe(input int ch, input bit with_tick, output logic [31:0] seen);
        @(negedge clk);
        seen = exp_time[31:0];
        sample_stb[ch] = 1'b1;
        us_tick = with_tick;
        if (with_tick) exp_time = exp_time + 64'd1;
        @(negedge clk);
        sample_stb = '0;
        us_tick = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(A_LO, d); check("R1 time low after reset", d, START[31:0]);
        rd(A_HI, d); check("R1 time high after reset", d, START[63:32]);
        rd(A_C0, d); check("R1 count0 after reset", d, 32'd0);
        rd(A_S0, d); check("R1 snap0 after reset", d, 32'd0);
        rd(A_C1, d); check("R1 count1 after reset", d, 32'd0);
        rd(A_S1, d); check("R1 snap1 after reset", d, 32'd0);
    endtask

    task automatic t_ticks;
        logic [31:0] d;
        ticks(3);
        rd(A_LO, d); check("R2 low after 3 ticks", d, exp_time[31:0]);
        repeat (5) @(negedge clk);
        rd(A_LO, d); check("R2 low holds without tick", d, exp_time[31:0]);
    endtask

    task automatic t_carry;
        logic [31:0] d;
        ticks(6);
        rd(A_LO, d); check("R3 low after wrap", d, exp_time[31:0]);
        rd(A_HI, d); check("R3 high after wrap", d, 32'd1);
    endtask

    task automatic t_read_port;
        logic [31:0] d;
        rd(A_HI, d);
        repeat (4) @(negedge clk);
        check("R8 rd_data holds while idle", rd_data, 32'd1);
        rd(12'h208, d); check("R8 unmapped 0x208 reads zero", d, 32'd0);
        rd(12'h310, d); check("R8 unmapped 0x310 reads zero", d, 32'd0);
    endtask

    task automatic t_strobes;
        logic [31:0] d, s0, s1a, s1b;
        ticks(2);
        strobe(0, 1'b0, s0);
        rd(A_C0, d); check("R4 count0 after one strobe", d, 32'd1);
        rd(A_S0, d); check("R5 snap0 equals time at strobe", d, s0);
        rd(A_C1, d); check("R4 count1 untouched by ch0", d, 32'd0);
        rd(A_S1, d); check("R4 snap1 untouched by ch0", d, 32'd0);
        strobe(1, 1'b1, s1a);
        strobe(1, 1'b0, s1b);
        rd(A_C1, d); check("R4 count1 after two strobes", d, 32'd2);
        rd(A_S1, d); check("R5 snap1 uses latest strobe time", d, s1b);
        check("R5 tick in strobe cycle not seen", s1b, s1a + 32'd1);
    endtask

    task automatic t_freeze;
        logic [31:0] d, s_old, s_new, cnt_start;
        ticks(1);
        strobe(0, 1'b0, s_old);
        rd(A_C0, cnt_start); check("R4 count0 before freeze", cnt_start, 32'd2);
        ticks(3);
        strobe(0, 1'b0, s_new);
        ticks(2);
        strobe(0, 1'b0, s_new);
        rd(A_S0, d); check("R6 frozen snap0 keeps paired value", d, s_old);
        rd(A_S0, d); check("R7 snap0 live after release", d, s_new);
        rd(A_C0, d); check("R6 count0 kept advancing", d, cnt_start + 32'd2);
        rd(A_S0, d); check("R6 snap0 pairs with new count", d, s_new);
    endtask

    task automatic t_same_cycle;
        logic [31:0] d, s_before, s_stb;
        rd(A_S0, s_before);
        ticks(4);
        @(negedge clk);
        s_stb = exp_time[31:0];
        rd_en = 1'b1;
        rd_addr = A_C0;
        sample_stb[0] = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        sample_stb = '0;
        d = rd_data;
        check("R9 count read beside strobe gives old count", d, 32'd4);
        rd(A_S0, d); check("R9 snap pairs with old count", d, s_before);
        rd(A_C0, d); check("R9 count after coincident strobe", d, 32'd5);
        rd(A_S0, d); check("R9 snap of coincident strobe", d, s_stb);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ticks();
        t_carry();
        t_read_port();
        t_strobes();
        t_freeze();
        t_same_cycle();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule